// File: doc/BRIEF.md
# Character Raster Position Generator

This block works out where the electron beam sits inside a text overlay window of 10 rows by 24 characters, each character cell being 8 dots wide and 8 dots tall. It runs on the character dot clock (one clock cycle per dot clock period). It takes one-cycle strobes marking the start of each scan line and the start of each field. From these it derives a display-active flag, the text row and column address for the character memory, the font row index, and the dot column index inside the current character.

The window position is set by two 6-bit offsets, counted in steps of two lines and two dot clocks. Characters can be enlarged to double or triple size in each direction. The first text row has its own pair of size codes and all later rows share a second pair. Enlarged text that would run past the next line strobe or field strobe is cut off, not wrapped. Font fetch, sync generation and video mixing sit downstream and upstream of this block.

Top module: `osd_raster_pos`

## Requirements
- R1: After reset every output is 0, and `active` stays low until both a line strobe and a field strobe have been seen.
- R2: Count the cycle after a line strobe as dot clock 0. The first displayed dot of a line is dot clock 2×`h_start`, and `active` rises there with `col_addr` and `dot_col` both 0.
- R3: A field strobe starts line 0. It may come alone or together with a line strobe in the same cycle, and the line that begins with it is line 0. Each later line strobe starts the next line. The first displayed line is line 2×`v_start`.
- R4: A horizontal size code gives the dot clocks per font dot: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 1.
- R5: A vertical size code gives the lines per font dot: 00 gives 1, 01 gives 2, 10 gives 3 and 11 gives 1.
- R6: Text row 0 uses `hsize_first` and `vsize_first`. Rows 1 to 9 use `hsize_rest` and `vsize_rest`.
- R7: `dot_col` steps 0 to 7 once per font dot, and `col_addr` advances when it wraps. After column 23 ends, `active` stays low for the rest of the line.
- R8: `font_row` steps 0 to 7 once per font dot line, and `row_addr` advances when it wraps. After row 9 ends, `active` stays low until the next field strobe.
- R9: A line strobe that arrives inside the window cuts the line short, and the next line restarts at column 0 and dot 0. A field strobe that arrives inside the window restarts the field at row 0 and font row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_p | input | 1 | One-cycle line start strobe |
| vsync_p | input | 1 | One-cycle field start strobe |
| h_start | input | 6 | Horizontal offset, in units of 2 dot clocks |
| v_start | input | 6 | Vertical offset, in units of 2 lines |
| hsize_first | input | 2 | Horizontal size code for text row 0 |
| hsize_rest | input | 2 | Horizontal size code for rows 1 to 9 |
| vsize_first | input | 2 | Vertical size code for text row 0 |
| vsize_rest | input | 2 | Vertical size code for rows 1 to 9 |
| active | output | 1 | Beam is inside the text window |
| row_addr | output | 4 | Text row address, 0 to 9 |
| col_addr | output | 5 | Text column address, 0 to 23 |
| font_row | output | 3 | Font row inside the character |
| dot_col | output | 3 | Dot column inside the character |

## Verification
A divider counter stuck or off by one shows up first in `dot_col`, inside the first enlarged font dot after `active` rises. The same fault reaches `col_addr` eight font dots later. A fault in the vertical chain only shows once per line, so a wrong lines-per-dot count shifts `font_row` by the second or third line of the window. A bad end-of-window flag shows either as `active` held high past column 23 or row 9, or as `active` dropping before the window ends. The bench compares every output on every cycle against a model built from line and dot positions, so each of these faults is caught in the cycle where it first appears.

// File: rtl/osd_raster_pos.sv
module osd_raster_pos #(
  parameter int ROWS  = 10,
  parameter int COLS  = 24,
  parameter int CELL  = 8,
  parameter int OFS_W = 6,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int DW = $clog2(CELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_p,
  input  logic             vsync_p,
  input  logic [OFS_W-1:0] h_start,
  input  logic [OFS_W-1:0] v_start,
  input  logic [1:0]       hsize_first,
  input  logic [1:0]       hsize_rest,
  input  logic [1:0]       vsize_first,
  input  logic [1:0]       vsize_rest,
  output logic             active,
  output logic [RW-1:0]    row_addr,
  output logic [CW-1:0]    col_addr,
  output logic [DW-1:0]    font_row,
  output logic [DW-1:0]    dot_col
);

  localparam int PW = OFS_W + 1;

  function automatic logic [1:0] span(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  logic [PW-1:0] hcnt, vcnt;
  logic          h_end, v_end;
  logic [1:0]    hsub, vsub;

  wire       first_row = (row_addr == '0);
  wire [1:0] hspan = span(first_row ? hsize_first : hsize_rest);
  wire [1:0] vspan = span(first_row ? vsize_first : vsize_rest);
  wire       h_in  = !h_end && (hcnt >= {h_start, 1'b0});
  wire       v_in  = !v_end && (vcnt >= {v_start, 1'b0});

  assign active = h_in && v_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt     <= '0;
      h_end    <= 1'b1;
      hsub     <= '0;
      dot_col  <= '0;
      col_addr <= '0;
    end else if (hsync_p) begin
      hcnt     <= '0;
      h_end    <= 1'b0;
      hsub     <= '0;
      dot_col  <= '0;
      col_addr <= '0;
    end else begin
      if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (h_in) begin
        if (hsub >= hspan - 2'd1) begin
          hsub <= '0;
          if (dot_col == DW'(CELL - 1)) begin
            dot_col <= '0;
            if (col_addr == CW'(COLS - 1)) h_end <= 1'b1;
            else col_addr <= col_addr + 1'b1;
          end else begin
            dot_col <= dot_col + 1'b1;
          end
        end else begin
          hsub <= hsub + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt     <= '0;
      v_end    <= 1'b1;
      vsub     <= '0;
      font_row <= '0;
      row_addr <= '0;
    end else if (vsync_p) begin
      vcnt     <= '0;
      v_end    <= 1'b0;
      vsub     <= '0;
      font_row <= '0;
      row_addr <= '0;
    end else if (hsync_p) begin
      if (vcnt != '1) vcnt <= vcnt + 1'b1;
      if (v_in) begin
        if (vsub >= vspan - 2'd1) begin
          vsub <= '0;
          if (font_row == DW'(CELL - 1)) begin
            font_row <= '0;
            if (row_addr == RW'(ROWS - 1)) v_end <= 1'b1;
            else row_addr <= row_addr + 1'b1;
          end else begin
            font_row <= font_row + 1'b1;
          end
        end else begin
          vsub <= vsub + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/osd_raster_pos_checker.sv
module osd_raster_pos_checker #(
  parameter int ROWS = 10,
  parameter int COLS = 24,
  parameter int CELL = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS),
  localparam int DW = $clog2(CELL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hsync_p,
  input logic          vsync_p,
  input logic          active,
  input logic [RW-1:0] row_addr,
  input logic [CW-1:0] col_addr,
  input logic [DW-1:0] font_row,
  input logic [DW-1:0] dot_col
);

  assert_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (col_addr == '0) && (dot_col == '0));

  assert_col_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col_addr <= CW'(COLS - 1)));

  assert_dot_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(hsync_p)) |->
      (dot_col == $past(dot_col)) || (dot_col == $past(dot_col) + DW'(1)));

  assert_row_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (row_addr <= RW'(ROWS - 1)));

  assert_hrestart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hsync_p) |-> (col_addr == '0) && (dot_col == '0));

  assert_vrestart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(vsync_p) |-> (row_addr == '0) && (font_row == '0));

endmodule

bind osd_raster_pos osd_raster_pos_checker #(.ROWS(ROWS), .COLS(COLS), .CELL(CELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .hsync_p(hsync_p), .vsync_p(vsync_p),
  .active(active), .row_addr(row_addr), .col_addr(col_addr),
  .font_row(font_row), .dot_col(dot_col)
);

// File: tb/osd_raster_pos_tb.sv
module osd_raster_pos_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync_p = 1'b0, vsync_p = 1'b0;
  logic [5:0] h_start = '0, v_start = '0;
  logic [1:0] hsize_first = '0, hsize_rest = '0, vsize_first = '0, vsize_rest = '0;
  logic       active;
  logic [3:0] row_addr;
  logic [4:0] col_addr;
  logic [2:0] font_row, dot_col;

  int checks = 0, errors = 0, shown = 0;
  int k = 0, L = 0;
  bit seen_h = 0, seen_v = 0, done = 0;

  always #4 clk = ~clk;

  osd_raster_pos u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_p(hsync_p), .vsync_p(vsync_p),
    .h_start(h_start), .v_start(v_start),
    .hsize_first(hsize_first), .hsize_rest(hsize_rest),
    .vsize_first(vsize_first), .vsize_rest(vsize_rest),
    .active(active), .row_addr(row_addr), .col_addr(col_addr),
    .font_row(font_row), .dot_col(dot_col)
  );

  function automatic int bspan(input logic [1:0] c);
    return (c == 2'b01) ? 2 : (c == 2'b10) ? 3 : 1;
  endfunction

  task automatic expect_at(output bit act, output int r, output int c, output int f, output int d);
    int vf, vr, hz, y, x;
    act = 0; r = 0; c = 0; f = 0; d = 0;
    if (!seen_h || !seen_v) return;
    vf = bspan(vsize_first);
    vr = bspan(vsize_rest);
    if (L < 2 * int'(v_start)) return;
    y = L - 2 * int'(v_start);
    if (y < 8 * vf) begin
      r = 0; f = y / vf;
    end else begin
      y = y - 8 * vf;
      r = 1 + y / (8 * vr);
      f = (y % (8 * vr)) / vr;
    end
    if (r > 9) return;
    hz = (r == 0) ? bspan(hsize_first) : bspan(hsize_rest);
    if (k < 2 * int'(h_start)) return;
    x = k - 2 * int'(h_start);
    c = x / (8 * hz);
    if (c > 23) return;
    d = (x % (8 * hz)) / hz;
    act = 1;
  endtask

  task automatic check(string tag);
    bit ea; int er, ec, ef, ed; bit bad;
    expect_at(ea, er, ec, ef, ed);
    checks++;
    bad = (active !== ea);
    if (ea && (int'(row_addr) != er || int'(col_addr) != ec ||
               int'(font_row) != ef || int'(dot_col) != ed)) bad = 1;
    if (bad) begin
      errors++;
      if (shown < 20) begin
        shown++;
        $display("FAIL %s line=%0d dot=%0d actual act=%0d row=%0d col=%0d font=%0d dot=%0d expected act=%0d row=%0d col=%0d font=%0d dot=%0d",
                 tag, L, k, active, row_addr, col_addr, font_row, dot_col, ea, er, ec, ef, ed);
      end
    end
  endtask

  task automatic frame(string tag, int hpv, int vpv, logic [1:0] hf, logic [1:0] hr,
                       logic [1:0] vf, logic [1:0] vr, int nlines, int len, bit with_v);
    for (int l = 0; l < nlines; l++) begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        check(tag);
        if (l == 0 && i == 0) begin
          h_start = hpv[5:0]; v_start = vpv[5:0];
          hsize_first = hf; hsize_rest = hr; vsize_first = vf; vsize_rest = vr;
        end
        hsync_p = (i == 0);
        vsync_p = (l == 0 && i == 0 && with_v);
        if (hsync_p) begin k = 0; seen_h = 1; end else k++;
        if (vsync_p) begin L = 0; seen_v = 1; end else if (hsync_p) L++;
      end
    end
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (active !== 1'b0 || row_addr !== '0 || col_addr !== '0 || font_row !== '0 || dot_col !== '0) begin
      errors++;
      $display("FAIL R1 reset state actual act=%0d row=%0d col=%0d font=%0d dot=%0d expected all 0",
               active, row_addr, col_addr, font_row, dot_col);
    end
    frame("R1 line strobes only", 0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 3, 150, 1'b0);
  endtask

  task automatic t_basic;
    frame("R7 R8 R3 basic window", 0, 0, 2'b00, 2'b00, 2'b00, 2'b00, 85, 210, 1'b1);
  endtask

  task automatic t_offset;
    frame("R2 R3 offsets 5/3", 5, 3, 2'b00, 2'b00, 2'b00, 2'b00, 90, 220, 1'b1);
    frame("R2 offset 63", 63, 0, 2'b00, 2'b00, 2'b00, 2'b00, 85, 320, 1'b1);
  endtask

  task automatic t_scale;
    frame("R4 R5 R6 mixed sizes", 1, 1, 2'b01, 2'b10, 2'b10, 2'b01, 175, 260, 1'b1);
  endtask

  task automatic t_code3;
    frame("R4 R5 code 11 is 1x", 0, 0, 2'b11, 2'b11, 2'b11, 2'b11, 85, 210, 1'b1);
  endtask

  task automatic t_clip;
    frame("R9 short lines cut field", 0, 0, 2'b01, 2'b00, 2'b00, 2'b10, 30, 100, 1'b1);
    frame("R9 field restart", 0, 0, 2'b01, 2'b00, 2'b00, 2'b10, 20, 100, 1'b1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_offset();
    t_scale();
    t_code3();
    t_clip();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=not finished expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule